// File: doc/BRIEF.md
# Router Mainboard IO Controller Registers

This block is the register file a router mainboard CPU uses for low-speed housekeeping IO. A simple synchronous register bus carries an address, separate read and write strobes, write data and read data. Through it, software bit-bangs two serial EEPROM ports, one on the mainboard and one steered to any of four module slots. It also reads which slots hold a module, acknowledges three interrupt sources, keeps a byte-wide IO mask, and reads a platform identity chosen by a strap, together with a few fixed status words.

Read data is combinational. It is valid in the same cycle as `bus_rd` and reads zero when no read is active. Writes and acknowledge side effects take effect at the clock edge that ends the access. Each interrupt is a level output. A one-cycle event pulse from its source sets the level, and it stays high until software acknowledges it. The network interrupt is held longer: only every sixteenth access to its status window clears it.

Top module: `io_ctrl_regs`

## Requirements
- R1: After reset the IO mask, the slot select, the network acknowledge counter and all three interrupt levels are zero, and every EEPROM output pin is low.
- R2: A write to offset 0x0000E drives the mainboard EEPROM pins from the write data: chip select from bit 0, clock from bit 1 and data-in from bit 2. A read of 0x0000E returns the mainboard EEPROM data-out on bit 3, with all other bits zero.
- R3: A write to offset 0x10008 latches bits [1:0] as the selected slot. In the same write, clock (bit 2), chip select (bit 4) and data-in (bit 6) are routed to that slot's EEPROM pins only, and the other slots' pins are low. A read of 0x10008 returns the selected slot's data-out on bit 7, with all other bits zero.
- R4: A read of offset 0x10006 returns 0xFFFF, except that for each present slot i (0..3) bits i, i+4, i+8 and i+12 read 0.
- R5: A read of offsets 0x20000 to 0x20003 returns 0x00FF. Every read or write there advances a counter. The access that brings the count to 16 clears the network interrupt and restarts the count at zero; no other access clears it.
- R6: Any access to offset 0x20004 clears the module management interrupt, and any access to offset 0x20006 clears the external interrupt. Reads of either offset return 0.
- R7: An interrupt event pulse sets its level at the next edge. If the event arrives in the same cycle as a clearing access, the level stays set.
- R8: Offset 0x20008 is an 8-bit IO mask that reads back the last byte written, with bits [15:8] reading zero.
- R9: Offset 0x30000 returns the platform code in bits [7:5], with all other bits zero. Strap value 0 selects code 0, strap 1 selects code 4, strap 2 selects code 3, and strap 3 selects code 0.
- R10: Fixed reads return 0x00FF at 0x00008, 0x1000 at 0x0000A and 0x0021 at 0x30004. Writes to these offsets leave their read values unchanged.
- R11: Reads of unmapped offsets return 0, and writes to them change no register and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 18 | Register byte offset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational, zero when idle |
| plat_strap | input | 2 | Platform identity strap |
| slot_present | input | 4 | High when a module sits in the slot |
| mb_cs | output | 1 | Mainboard EEPROM chip select |
| mb_sk | output | 1 | Mainboard EEPROM serial clock |
| mb_di | output | 1 | Mainboard EEPROM serial data into the device |
| mb_do | input | 1 | Mainboard EEPROM serial data out of the device |
| nm_cs | output | 4 | Per-slot module EEPROM chip select |
| nm_sk | output | 4 | Per-slot module EEPROM serial clock |
| nm_di | output | 4 | Per-slot module EEPROM data into the device |
| nm_do | input | 4 | Per-slot module EEPROM data out of the device |
| net_evt | input | 1 | Network interrupt event pulse |
| mgmt_evt | input | 1 | Module management interrupt event pulse |
| ext_evt | input | 1 | External interrupt event pulse |
| net_irq | output | 1 | Network interrupt level |
| mgmt_irq | output | 1 | Module management interrupt level |
| ext_irq | output | 1 | External interrupt level |

## Verification
The properties assume that the bus holds a single strobe per cycle and that `bus_addr` is stable while that strobe is high. They also assume that an event pulse lasts one cycle and arrives at any time relative to bus traffic. The stimulus changes every input on the falling clock edge, raises at most one strobe at a time, and drops it before the next access. It places event pulses both between accesses and on top of an acknowledge, to reach the case where set beats clear. The strap and slot-present inputs are treated as static straps. They change only while the bus is idle, so a read never sees them move mid-cycle.

// File: rtl/io_ctrl_regs.sv
module io_ctrl_regs #(
  parameter int AW        = 18,
  parameter int DW        = 16,
  parameter int NSLOT     = 4,
  parameter int CLR_COUNT = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    bus_addr,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  input  logic [1:0]       plat_strap,
  input  logic [NSLOT-1:0] slot_present,
  output logic             mb_cs,
  output logic             mb_sk,
  output logic             mb_di,
  input  logic             mb_do,
  output logic [NSLOT-1:0] nm_cs,
  output logic [NSLOT-1:0] nm_sk,
  output logic [NSLOT-1:0] nm_di,
  input  logic [NSLOT-1:0] nm_do,
  input  logic             net_evt,
  input  logic             mgmt_evt,
  input  logic             ext_evt,
  output logic             net_irq,
  output logic             mgmt_irq,
  output logic             ext_irq
);
  localparam int SW = $clog2(NSLOT);
  localparam int CW = $clog2(CLR_COUNT);

  localparam logic [AW-1:0] A_FLASHWP = AW'('h00008);
  localparam logic [AW-1:0] A_BOOTSZ  = AW'('h0000A);
  localparam logic [AW-1:0] A_MBROM   = AW'('h0000E);
  localparam logic [AW-1:0] A_PRESENT = AW'('h10006);
  localparam logic [AW-1:0] A_NMROM   = AW'('h10008);
  localparam logic [AW-1:0] A_NETSTAT = AW'('h20000);
  localparam logic [AW-1:0] A_MGMTACK = AW'('h20004);
  localparam logic [AW-1:0] A_EXTACK  = AW'('h20006);
  localparam logic [AW-1:0] A_IOMASK  = AW'('h20008);
  localparam logic [AW-1:0] A_PLATID  = AW'('h30000);
  localparam logic [AW-1:0] A_ENVSTAT = AW'('h30004);

  logic          acc;
  logic          net_acc;
  logic          net_clr;
  logic [CW-1:0] net_cnt;
  logic [SW-1:0] slot_sel;
  logic          nm_cs_q, nm_sk_q, nm_di_q;
  logic [7:0]    io_mask;
  logic [2:0]    plat_code;
  logic [DW-1:0] present_word;
  logic          unused_ok;

  assign acc       = bus_rd | bus_wr;
  assign net_acc   = acc && (bus_addr[AW-1:2] == A_NETSTAT[AW-1:2]);
  assign net_clr   = net_acc && (net_cnt == CW'(CLR_COUNT - 1));
  assign unused_ok = ^{bus_wdata[DW-1:8], bus_wdata[5], bus_wdata[3]};

  always_comb begin
    present_word = '1;
    for (int i = 0; i < NSLOT; i++)
      if (slot_present[i])
        for (int n = 0; n < DW / NSLOT; n++)
          present_word[n*NSLOT + i] = 1'b0;
  end

  always_comb begin
    case (plat_strap)
      2'd1:    plat_code = 3'd4;
      2'd2:    plat_code = 3'd3;
      default: plat_code = 3'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mb_cs <= 1'b0; mb_sk <= 1'b0; mb_di <= 1'b0;
      nm_cs_q <= 1'b0; nm_sk_q <= 1'b0; nm_di_q <= 1'b0;
      slot_sel <= '0;
      io_mask  <= '0;
    end else if (bus_wr) begin
      if (bus_addr == A_MBROM) begin
        mb_cs <= bus_wdata[0];
        mb_sk <= bus_wdata[1];
        mb_di <= bus_wdata[2];
      end
      if (bus_addr == A_NMROM) begin
        slot_sel <= bus_wdata[SW-1:0];
        nm_sk_q  <= bus_wdata[2];
        nm_cs_q  <= bus_wdata[4];
        nm_di_q  <= bus_wdata[6];
      end
      if (bus_addr == A_IOMASK)
        io_mask <= bus_wdata[7:0];
    end
  end

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    assign nm_cs[s] = nm_cs_q && (slot_sel == SW'(s));
    assign nm_sk[s] = nm_sk_q && (slot_sel == SW'(s));
    assign nm_di[s] = nm_di_q && (slot_sel == SW'(s));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      net_cnt  <= '0;
      net_irq  <= 1'b0;
      mgmt_irq <= 1'b0;
      ext_irq  <= 1'b0;
    end else begin
      if (net_acc) net_cnt <= net_clr ? '0 : net_cnt + 1'b1;
      net_irq  <= net_evt  | (net_irq  & ~net_clr);
      mgmt_irq <= mgmt_evt | (mgmt_irq & ~(acc && bus_addr == A_MGMTACK));
      ext_irq  <= ext_evt  | (ext_irq  & ~(acc && bus_addr == A_EXTACK));
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (bus_addr[AW-1:2] == A_NETSTAT[AW-1:2])
        bus_rdata = DW'('h00FF);
      else
        case (bus_addr)
          A_FLASHWP: bus_rdata = DW'('h00FF);
          A_BOOTSZ:  bus_rdata = DW'('h1000);
          A_MBROM:   bus_rdata[3] = mb_do;
          A_PRESENT: bus_rdata = present_word;
          A_NMROM:   bus_rdata[7] = nm_do[slot_sel];
          A_IOMASK:  bus_rdata[7:0] = io_mask;
          A_PLATID:  bus_rdata[7:5] = plat_code;
          A_ENVSTAT: bus_rdata = DW'('h0021);
          default:   bus_rdata = '0;
        endcase
    end
  end
endmodule

// File: rtl/io_ctrl_regs_chk.sv
module io_ctrl_regs_chk #(
  parameter int AW    = 18,
  parameter int DW    = 16,
  parameter int NSLOT = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [AW-1:0]    bus_addr,
  input logic             bus_wr,
  input logic             bus_rd,
  input logic [DW-1:0]    bus_wdata,
  input logic [DW-1:0]    bus_rdata,
  input logic [NSLOT-1:0] nm_cs,
  input logic             net_evt,
  input logic             mgmt_evt,
  input logic             ext_evt,
  input logic             net_irq,
  input logic             mgmt_irq,
  input logic             ext_irq,
  input logic [7:0]       io_mask
);
  logic net_win;
  assign net_win = (bus_rd | bus_wr) && (bus_addr[AW-1:2] == AW'('h20000 >> 2));

  AST_NET_SET:   assert property (@(posedge clk) disable iff (!rst_n) net_evt |=> net_irq); // R7
  AST_MGMT_SET:  assert property (@(posedge clk) disable iff (!rst_n) mgmt_evt |=> mgmt_irq); // R7
  AST_EXT_SET:   assert property (@(posedge clk) disable iff (!rst_n) ext_evt |=> ext_irq); // R7
  AST_MGMT_ACK:  assert property (@(posedge clk) disable iff (!rst_n)
                   ((bus_rd | bus_wr) && bus_addr == AW'('h20004) && !mgmt_evt) |=> !mgmt_irq); // R6
  AST_EXT_ACK:   assert property (@(posedge clk) disable iff (!rst_n)
                   ((bus_rd | bus_wr) && bus_addr == AW'('h20006) && !ext_evt) |=> !ext_irq); // R6
  AST_NET_HOLD:  assert property (@(posedge clk) disable iff (!rst_n)
                   (!net_evt && !net_win) |=> $stable(net_irq)); // R5
  AST_ONE_SLOT:  assert property (@(posedge clk) disable iff (!rst_n) $onehot0(nm_cs)); // R3
  AST_PRES_REP:  assert property (@(posedge clk) disable iff (!rst_n)
                   (bus_rd && bus_addr == AW'('h10006)) |->
                   (bus_rdata[3:0] == bus_rdata[7:4] && bus_rdata[7:0] == bus_rdata[15:8])); // R4
  AST_MASK_WR:   assert property (@(posedge clk) disable iff (!rst_n)
                   (bus_wr && bus_addr == AW'('h20008)) |=> io_mask == $past(bus_wdata[7:0])); // R8
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n) !bus_rd |-> bus_rdata == '0); // R11
endmodule

bind io_ctrl_regs io_ctrl_regs_chk #(.AW(AW), .DW(DW), .NSLOT(NSLOT)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .nm_cs(nm_cs),
  .net_evt(net_evt), .mgmt_evt(mgmt_evt), .ext_evt(ext_evt),
  .net_irq(net_irq), .mgmt_irq(mgmt_irq), .ext_irq(ext_irq), .io_mask(io_mask)
);

// File: tb/io_ctrl_regs_bench.sv
module io_ctrl_regs_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 11;
  localparam logic [17:0] VA [NV] = '{18'h00008, 18'h0000A, 18'h30004, 18'h10006, 18'h30000,
                                      18'h20008, 18'h0000C, 18'h10004, 18'h00100, 18'h20004, 18'h20006};
  localparam logic [15:0] VE [NV] = '{16'h00FF, 16'h1000, 16'h0021, 16'hAAAA, 16'h0080,
                                      16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000};

  logic clk = 0, rst_n = 0;
  logic [17:0] bus_addr = '0;
  logic bus_wr = 0, bus_rd = 0;
  logic [15:0] bus_wdata = '0, bus_rdata;
  logic [1:0] plat_strap = 2'd1;
  logic [3:0] slot_present = 4'b0101;
  logic mb_cs, mb_sk, mb_di, mb_do = 0;
  logic [3:0] nm_cs, nm_sk, nm_di, nm_do = '0;
  logic net_evt = 0, mgmt_evt = 0, ext_evt = 0;
  logic net_irq, mgmt_irq, ext_irq;
  int errors = 0, checks = 0;
  logic [15:0] rv;

  always #(CLK_PERIOD/2) clk = ~clk;

  io_ctrl_regs u_io_ctrl_regs (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [17:0] a, output logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1;
    #1 d = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic wr(input logic [17:0] a, input logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic pulse_net();
    @(negedge clk); net_evt = 1; @(negedge clk); net_evt = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 pins", {mb_cs, mb_sk, mb_di, nm_cs, nm_sk, nm_di}, 0);
    check("R1 irqs", {net_irq, mgmt_irq, ext_irq}, 0);

    for (int i = 0; i < NV; i++) begin
      rd(VA[i], rv);
      check("R10 R4 R9 R8 R11 table", rv, VE[i]);
    end

    // R2 mainboard EEPROM
    wr(18'h0000E, 16'h0005);
    check("R2 pins", {mb_cs, mb_sk, mb_di}, 3'b101);
    mb_do = 1; rd(18'h0000E, rv); check("R2 readback", rv, 16'h0008);
    mb_do = 0; rd(18'h0000E, rv); check("R2 readback low", rv, 16'h0000);

    // R3 module EEPROM steering
    wr(18'h10008, 16'h0056);
    check("R3 slot2", {nm_cs, nm_sk, nm_di}, {4'b0100, 4'b0100, 4'b0100});
    nm_do = 4'b0100; rd(18'h10008, rv); check("R3 do sel", rv, 16'h0080);
    nm_do = 4'b1011; rd(18'h10008, rv); check("R3 do other", rv, 16'h0000);
    wr(18'h10008, 16'h0011);
    check("R3 slot1", {nm_cs, nm_sk, nm_di}, {4'b0010, 4'b0000, 4'b0000});

    // R4 presence pattern
    slot_present = 4'b1000; rd(18'h10006, rv); check("R4 slot3", rv, 16'h7777);
    slot_present = 4'b0000; rd(18'h10006, rv); check("R4 none", rv, 16'hFFFF);

    // R9 platform codes
    plat_strap = 2'd0; rd(18'h30000, rv); check("R9 strap0", rv, 16'h0000);
    plat_strap = 2'd2; rd(18'h30000, rv); check("R9 strap2", rv, 16'h0060);
    plat_strap = 2'd3; rd(18'h30000, rv); check("R9 strap3", rv, 16'h0000);

    // R8 IO mask
    wr(18'h20008, 16'hBEA5); rd(18'h20008, rv); check("R8 mask", rv, 16'h00A5);

    // R10 writes to read-only
    wr(18'h30004, 16'h0000); rd(18'h30004, rv); check("R10 env", rv, 16'h0021);
    wr(18'h00008, 16'h0000); rd(18'h00008, rv); check("R10 flash", rv, 16'h00FF);

    // R11 unmapped write ignored
    wr(18'h00104, 16'hFFFF);
    rd(18'h00104, rv); check("R11 unmapped", rv, 16'h0000);
    rd(18'h20008, rv); check("R11 mask kept", rv, 16'h00A5);
    check("R11 pins kept", {mb_cs, mb_sk, mb_di, nm_cs}, {3'b101, 4'b0010});

    // R5 network interrupt delayed clear (counter starts at 0)
    pulse_net();
    check("R7 net set", net_irq, 1);
    for (int k = 1; k <= 15; k++) begin
      rd(18'h20000 + 18'(k % 4), rv);
      if (k == 1) check("R5 value", rv, 16'h00FF);
    end
    check("R5 held at 15", net_irq, 1);
    rd(18'h20003, rv);
    check("R5 cleared at 16", net_irq, 0);
    pulse_net();
    for (int k = 1; k <= 15; k++) wr(18'h20002, 16'h0000);
    check("R5 restart held", net_irq, 1);
    wr(18'h20001, 16'h0000);
    check("R5 restart clear", net_irq, 0);

    // R6 acknowledges
    @(negedge clk); mgmt_evt = 1; ext_evt = 1; @(negedge clk); mgmt_evt = 0; ext_evt = 0;
    check("R7 mgmt ext set", {mgmt_irq, ext_irq}, 2'b11);
    rd(18'h20004, rv); check("R6 mgmt read", rv, 0);
    check("R6 mgmt cleared", {mgmt_irq, ext_irq}, 2'b01);
    wr(18'h20006, 16'hFFFF);
    check("R6 ext cleared", ext_irq, 0);

    // R7 set wins over clear in the same cycle
    @(negedge clk); bus_addr = 18'h20004; bus_rd = 1; mgmt_evt = 1;
    @(negedge clk); bus_rd = 0; mgmt_evt = 0;
    check("R7 set wins", mgmt_irq, 1);

    // R1 reset again clears state
    @(negedge clk); rst_n = 0; @(negedge clk); rst_n = 1;
    check("R1 rereset", {mgmt_irq, nm_cs, mb_cs}, 0);
    rd(18'h20008, rv); check("R1 mask", rv, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule